// File: doc/BRIEF.md
# SDRAM Mode-Programmed Burst Timing Unit

This block models the device side of a single-bank SDRAM column path. The controller presents a command each clock on a plain two-bit command bus, together with a column address and write data. A LOAD MODE command copies the address bits into a mode register. That register sets three things: how many cycles pass between a READ and its first data word, the burst length, and whether writes use the burst or touch a single location.

The unit schedules the data bus around those settings. The output enable turns on one cycle ahead of the first read word. Read words then follow in wrapped sequential order, and the enable and the valid strobe drop together after the last word. Write bursts take one data word per cycle, starting with the word that arrives with the WRITE. A small register array holds the data.

The data bus runs on fixed cycle timing and has no back-pressure. The controller must present write words on the exact cycles that follow the WRITE, and it must take read words on the cycles in which `rvalid_o` is high. While a burst is in progress, the unit accepts nothing but NOP.

Top module: `sdr_burst_timer`

## Requirements
- R1: After reset, `dq_oe_o`, `rvalid_o` and `mode_illegal_o` are low. The mode in force is latency 2, burst length 1, with burst writes enabled.
- R2: Command codes are NOP=0, LOAD=1, READ=2, WRITE=3. A LOAD in an idle cycle stores `addr_i[9:0]`, and the new mode governs the next command. The fields are:
  - bits [2:0] give the burst length: 000, 001, 010 and 011 mean 1, 2, 4 and 8.
  - bit 3 is the ordering, where 0 means sequential.
  - bits [6:4] give the latency: 010 means 2 and 011 means 3.
  - bits [8:7] are the operating mode, where 00 means normal.
  - bit 9 makes writes single-location.
- R3: A READ sampled at edge n with latency m gives the first word on `rdata_o`, with `rvalid_o` high, in the cycle that follows edge n+m.
- R4: `dq_oe_o` goes high in the cycle after edge n+m-1. That is exactly one cycle before `rvalid_o` rises, and `rvalid_o` is never high without `dq_oe_o`.
- R5: A read delivers exactly burst-length words on consecutive cycles. Word i comes from column `(c & ~(BL-1)) | ((c+i) & (BL-1))`, where c is the READ column.
- R6: `dq_oe_o` and `rvalid_o` both fall in the cycle after the final read word.
- R7: When bit 9 is 0, a WRITE at edge n stores the `wdata_i` values sampled at edges n to n+BL-1 into the wrapped columns, in the same order that R5 gives for reads.
- R8: When bit 9 is 1, a WRITE stores only the word sampled with the command, at its own column, and the unit is idle on the next cycle. Reads still use the programmed burst length.
- R9: Any command other than NOP that arrives during a read or write burst is ignored, and this includes LOAD.
- R10: `mode_illegal_o` is high while the stored mode has any of the following: operating mode not 00, latency code not 010 or 011, burst code above 011, or ordering bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command code: NOP, LOAD, READ or WRITE |
| addr_i | input | ADDR_W (10) | Column address for READ/WRITE; mode value for LOAD |
| wdata_i | input | DATA_W (16) | Write data word |
| rdata_o | output | DATA_W (16) | Read data word |
| rvalid_o | output | 1 | High while `rdata_o` carries a burst word |
| dq_oe_o | output | 1 | Data bus output enable |
| mode_illegal_o | output | 1 | Stored mode holds a reserved or unsupported value |

## Verification
The hardest case to reach from the ports is a LOAD that arrives in the middle of a read, while the latency countdown is still running and no data has appeared yet. The bench issues a READ and, on the very next cycle, issues a LOAD that would switch the latency to 3. It lets that burst drain, then times a fresh READ cycle by cycle. The fresh read must still show latency 2, which proves the mid-burst LOAD was dropped. The single-location write case gets a similar treatment. The bench first fills the neighbouring columns through a burst write, then writes with bit 9 set while driving four words, and finally reads the whole aligned block back.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RWAIT,
    ST_RLEAD,
    ST_RBURST,
    ST_WBURST
  } seq_e;

  // Bit order matches the address bits loaded by LOAD MODE.
  typedef struct packed {
    logic       wr_single;  // bit 9
    logic [1:0] op_mode;    // bits 8:7
    logic [2:0] lat_code;   // bits 6:4
    logic       order;      // bit 3
    logic [2:0] len_code;   // bits 2:0
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
  localparam int BEAT_W = 4;  // holds burst lengths up to 8
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  mode_t             load_val,
  output logic              lat3,
  output logic              wr_single,
  output logic [BEAT_W-1:0] blen,
  output logic              illegal
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '{wr_single: 1'b0, op_mode: 2'b00, lat_code: 3'b010,
                  order: 1'b0, len_code: 3'b000};
    end else if (load_en) begin
      mode_q <= load_val;
    end
  end

  always_comb begin
    lat3      = (mode_q.lat_code == 3'b011);
    wr_single = mode_q.wr_single;
    case (mode_q.len_code)
      3'b001:  blen = BEAT_W'(2);
      3'b010:  blen = BEAT_W'(4);
      3'b011:  blen = BEAT_W'(8);
      default: blen = BEAT_W'(1);
    endcase
    illegal = (mode_q.op_mode != 2'b00)
            || !((mode_q.lat_code == 3'b010) || (mode_q.lat_code == 3'b011))
            || mode_q.len_code[2]
            || mode_q.order;
  end
endmodule

// File: rtl/sdr_burst_addr.sv
module sdr_burst_addr
  import sdr_pkg::*;
#(
  parameter int COL_W = 6
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] beat,
  input  logic [BEAT_W-1:0] blen,
  output logic [COL_W-1:0]  col
);
  logic [COL_W-1:0] mask;

  always_comb begin
    mask = COL_W'(blen - BEAT_W'(1));
    col  = (base & ~mask) | ((base + COL_W'(beat)) & mask);
  end
endmodule

// File: rtl/sdr_array.sv
module sdr_array #(
  parameter int COL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[col] <= wdata;
  end

  assign rdata = cells[col];
endmodule

// File: rtl/sdr_burst_timer.sv
module sdr_burst_timer
  import sdr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              dq_oe_o,
  output logic              mode_illegal_o
);
  cmd_e              cmd;
  seq_e              state;
  logic              idle, load_en, wr_en;
  logic              lat3, wr_single;
  logic [BEAT_W-1:0] blen, beat_q, beat_sel;
  logic [COL_W-1:0]  base_q, base_sel, col;
  logic [1:0]        dly_q;
  logic [DATA_W-1:0] arr_rdata, rdata_q;
  logic              oe_q, rv_q;

  always_comb begin
    cmd      = cmd_e'(cmd_i);
    idle     = (state == ST_IDLE);
    load_en  = idle && (cmd == CMD_LOAD);
    wr_en    = (idle && (cmd == CMD_WRITE)) || (state == ST_WBURST);
    base_sel = idle ? addr_i[COL_W-1:0] : base_q;
    beat_sel = idle ? '0 : beat_q;
  end

  sdr_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (mode_t'(addr_i[MODE_W-1:0])),
    .lat3      (lat3),
    .wr_single (wr_single),
    .blen      (blen),
    .illegal   (mode_illegal_o)
  );

  sdr_burst_addr #(.COL_W(COL_W)) u_addr (
    .base (base_sel),
    .beat (beat_sel),
    .blen (blen),
    .col  (col)
  );

  sdr_array #(.COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (wr_en),
    .col   (col),
    .wdata (wdata_i),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      beat_q  <= '0;
      dly_q   <= '0;
      oe_q    <= 1'b0;
      rv_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd == CMD_READ) begin
            base_q <= addr_i[COL_W-1:0];
            beat_q <= '0;
            dly_q  <= lat3 ? 2'd2 : 2'd1;
            state  <= ST_RWAIT;
          end else if (cmd == CMD_WRITE && !wr_single && blen > BEAT_W'(1)) begin
            base_q <= addr_i[COL_W-1:0];
            beat_q <= BEAT_W'(1);
            state  <= ST_WBURST;
          end
        end
        ST_RWAIT: begin
          if (dly_q == 2'd1) begin
            oe_q  <= 1'b1;
            state <= ST_RLEAD;
          end else begin
            dly_q <= dly_q - 2'd1;
          end
        end
        ST_RLEAD: begin
          rdata_q <= arr_rdata;
          rv_q    <= 1'b1;
          beat_q  <= BEAT_W'(1);
          state   <= ST_RBURST;
        end
        ST_RBURST: begin
          if (beat_q == blen) begin
            rv_q  <= 1'b0;
            oe_q  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            rdata_q <= arr_rdata;
            beat_q  <= beat_q + BEAT_W'(1);
          end
        end
        ST_WBURST: begin
          if (beat_q == blen - BEAT_W'(1)) state <= ST_IDLE;
          else beat_q <= beat_q + BEAT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rv_q;
  assign dq_oe_o  = oe_q;
endmodule

// File: rtl/sdr_burst_timer_chk.sv
module sdr_burst_timer_chk
  import sdr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_i,
  input logic              rvalid_o,
  input logic              dq_oe_o,
  input logic              idle,
  input logic              lat3,
  input logic              wr_single,
  input logic [BEAT_W-1:0] blen
);
  logic [BEAT_W:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (rvalid_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R3
  lat2_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_i == 2'd2 && !lat3) |=> !dq_oe_o ##1 (dq_oe_o && !rvalid_o) ##1 rvalid_o);

  // R3
  lat3_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_i == 2'd2 && lat3) |=> !dq_oe_o ##1 !dq_oe_o ##1 (dq_oe_o && !rvalid_o) ##1 rvalid_o);

  // R4
  oe_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> dq_oe_o);

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid_o) |-> !dq_oe_o);

  // R5
  burst_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid_o) |-> (run_q == {1'b0, blen}));

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_i == 2'd3 && wr_single) |=> idle);

  // R9
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd_i == 2'd1) |=> ($stable(lat3) && $stable(wr_single) && $stable(blen)));
endmodule

bind sdr_burst_timer sdr_burst_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_i     (cmd_i),
  .rvalid_o  (rvalid_o),
  .dq_oe_o   (dq_oe_o),
  .idle      (idle),
  .lat3      (lat3),
  .wr_single (wr_single),
  .blen      (blen)
);

// File: tb/sdr_burst_timer_bench.sv
`timescale 1ns/1ps
module sdr_burst_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_i = 2'd0;
  logic [9:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o, dq_oe_o, mode_illegal_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] shadow [64];

  always #2.5 clk = ~clk;

  sdr_burst_timer u_sdr_burst_timer (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .dq_oe_o(dq_oe_o),
    .mode_illegal_o(mode_illegal_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mw(input bit ws, input logic [1:0] op,
                                    input logic [2:0] lat, input bit ord,
                                    input logic [2:0] lenc);
    return {ws, op, lat, ord, lenc};
  endfunction

  function automatic int wrap(input int c, input int i, input int bl);
    return (c & ~(bl - 1)) | ((c + i) & (bl - 1));
  endfunction

  task automatic load_mode(input logic [9:0] m);
    @(negedge clk); cmd_i = 2'd1; addr_i = m;
    @(negedge clk); cmd_i = 2'd0;
  endtask

  // Drives nw words; the shadow follows R7 / R8.
  task automatic run_write(input int c, input int nw, input int bl, input bit single,
                           input logic [15:0] seed);
    @(negedge clk); cmd_i = 2'd3; addr_i = 10'(c); wdata_i = seed;
    if (single) shadow[c] = seed;
    else shadow[wrap(c, 0, bl)] = seed;
    for (int i = 1; i < nw; i++) begin
      @(negedge clk); cmd_i = 2'd0; wdata_i = seed + 16'(i);
      if (!single && i < bl) shadow[wrap(c, i, bl)] = seed + 16'(i);
    end
    @(negedge clk); cmd_i = 2'd0; wdata_i = 16'hdead;
  endtask

  // j counts negedges after edge n at which the READ was sampled.
  task automatic run_read(input int c, input int m, input int bl, input string tag);
    @(negedge clk); cmd_i = 2'd2; addr_i = 10'(c);
    @(negedge clk); cmd_i = 2'd0;
    for (int j = 0; j < m + bl + 2; j++) begin
      bit eoe, erv;
      eoe = (j >= m - 1) && (j <= m + bl - 1);
      erv = (j >= m) && (j < m + bl);
      chk(dq_oe_o == eoe, {tag, " R4/R6 dq_oe"}, 32'(dq_oe_o), 32'(eoe));
      chk(rvalid_o == erv, {tag, " R3/R6 rvalid"}, 32'(rvalid_o), 32'(erv));
      if (erv)
        chk(rdata_o == shadow[wrap(c, j - m, bl)], {tag, " R5 word"},
            32'(rdata_o), 32'(shadow[wrap(c, j - m, bl)]));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(dq_oe_o == 1'b0, "R1 oe", 32'(dq_oe_o), 0);
    chk(rvalid_o == 1'b0, "R1 rvalid", 32'(rvalid_o), 0);
    chk(mode_illegal_o == 1'b0, "R1 illegal", 32'(mode_illegal_o), 0);
    run_write(9, 1, 1, 1'b0, 16'h1111);
    run_read(9, 2, 1, "R1 default");
  endtask

  task automatic t_lat3_bl8;
    load_mode(mw(1'b0, 2'b00, 3'b011, 1'b0, 3'b011));
    run_write(0, 8, 8, 1'b0, 16'h0a00);
    run_read(3, 3, 8, "R2 R7 lat3 bl8");
    load_mode(mw(1'b0, 2'b00, 3'b011, 1'b0, 3'b000));
    run_read(2, 3, 1, "R2 lat3 bl1");
  endtask

  task automatic t_lat2_bl4;
    load_mode(mw(1'b0, 2'b00, 3'b010, 1'b0, 3'b010));
    run_write(5, 4, 4, 1'b0, 16'h0b00);
    run_read(6, 2, 4, "R7 lat2 bl4");
  endtask

  task automatic t_single_write;
    load_mode(mw(1'b0, 2'b00, 3'b010, 1'b0, 3'b010));
    run_write(16, 4, 4, 1'b0, 16'h0c00);
    load_mode(mw(1'b1, 2'b00, 3'b010, 1'b0, 3'b010));
    run_write(18, 4, 4, 1'b1, 16'h0d00);
    run_read(16, 2, 4, "R8 single write");
  endtask

  task automatic t_busy_load;
    load_mode(mw(1'b0, 2'b00, 3'b010, 1'b0, 3'b001));
    @(negedge clk); cmd_i = 2'd2; addr_i = 10'd16;
    @(negedge clk); cmd_i = 2'd1; addr_i = mw(1'b0, 2'b00, 3'b011, 1'b0, 3'b011);
    @(negedge clk); cmd_i = 2'd0;
    repeat (6) @(negedge clk);
    run_read(17, 2, 2, "R9 ignored load");
  endtask

  task automatic t_illegal;
    load_mode(mw(1'b0, 2'b01, 3'b010, 1'b0, 3'b000));
    chk(mode_illegal_o == 1'b1, "R10 op mode", 32'(mode_illegal_o), 1);
    load_mode(mw(1'b0, 2'b00, 3'b001, 1'b0, 3'b000));
    chk(mode_illegal_o == 1'b1, "R10 latency", 32'(mode_illegal_o), 1);
    load_mode(mw(1'b0, 2'b00, 3'b010, 1'b0, 3'b111));
    chk(mode_illegal_o == 1'b1, "R10 length", 32'(mode_illegal_o), 1);
    load_mode(mw(1'b0, 2'b00, 3'b010, 1'b1, 3'b000));
    chk(mode_illegal_o == 1'b1, "R10 order", 32'(mode_illegal_o), 1);
    load_mode(mw(1'b0, 2'b00, 3'b011, 1'b0, 3'b010));
    chk(mode_illegal_o == 1'b0, "R10 legal", 32'(mode_illegal_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lat3_bl8();
    t_lat2_bl4();
    t_single_write();
    t_busy_load();
    t_illegal();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule